// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block is the hardware for-loop behind a vectorised instruction. It is started once per instruction with a vector length, a sub-vector length code, a scalar/vector flag and a base register number for each of the source and the destination, and a three-bit twin-predication code. It then issues at most one element operation per clock. For each operation it presents a source register number, a destination register number and a sub-element index. Execution units downstream consume these values on the issue strobe.

The source and the destination each have their own position counter. Each counter skips positions whose own predicate bit is inactive, so one loop can compress, expand or move data between masked positions. A predicate bit gates a whole sub-vector group. A scalar operand keeps its register number fixed on every iteration. If that scalar operand is also predicated, the loop stops after its first issued element, which gives splat and select behaviour.

The live offsets stay visible at the ports at all times. The hold input freezes the loop, for example while an interrupt is taken. A later start can resume from saved offsets.

The controller has three states:

- `ST_IDLE` waits for start.
- `ST_RUN` steps the two offsets and issues.
- `ST_DONE` lasts one cycle and drives the done pulse.

It has five transitions:

- IDLE→RUN: start with in-range offsets.
- IDLE→DONE: start with an empty range.
- RUN→RUN: stepping, or held by hold.
- RUN→DONE: finish.
- DONE→IDLE: always.

Top module: `eloop_seq`

## Requirements
- R1: After reset `busy`, `issue` and `done` are 0, and `src_offs`, `dst_offs` and `sub_offs` are 0.
- R2: A scalar operand (`*_vec`=0) presents its base register number on every issue. A vector operand presents base plus its current offset, modulo 2^REG_W (for example, base 126 steps to 126, 127, 0).
- R3: The sub-vector length code maps 2'b00→1, 2'b01→2, 2'b10→3 and 2'b11→4 sub-elements per element. `sub_idx` counts 0 up to count−1 in consecutive issues before the offsets advance.
- R4: Bit 0 of `tpred` applies `mask_a` to the source, and bit 1 applies `mask_b` to the destination. Bit 2 inverts whichever mask is applied, so an active bit becomes 0. The codes 3'b000 and 3'b100 are both unpredicated.
- R5: The source and destination offsets advance independently. In a cycle where an operand's predicate bit at its offset is inactive, only that operand's offset advances by one and nothing issues. An issue happens only when both positions are active.
- R6: A predicate bit gates an entire sub-vector group. Either every sub-element of an element issues, or none does.
- R7: When a predicated operand is scalar, the loop ends after the last sub-element of the first element that issues.
- R8: The loop finishes when either offset reaches `vl`. `done` is high for exactly one cycle, the cycle after the last issue or skip. While `done` is high, all offsets read 0.
- R9: If `vl`=0, or a start offset is at least `vl`, there is no issue, and `done` rises in the cycle right after the start.
- R10: While `hold` is 1 in the running state, `issue` is 0 and the offsets stay unchanged.
- R11: A start loads `src_offs`, `dst_offs` and `sub_offs` from `start_src_offs`, `start_dst_offs` and `start_sub_offs`. The loop then resumes from those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (accepted in idle) |
| hold | input | 1 | Freeze the running loop |
| vl | input | VL_W (7) | Vector length, 0..MAX_VL |
| svlen | input | 2 | Sub-vector length code |
| src_vec | input | 1 | Source is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or scalar (0) |
| src_base | input | REG_W (7) | Source base register number |
| dst_base | input | REG_W (7) | Destination base register number |
| tpred | input | 3 | Twin-predication code |
| mask_a | input | MAX_VL (64) | Source predicate mask, held stable during the loop |
| mask_b | input | MAX_VL (64) | Destination predicate mask, held stable during the loop |
| start_src_offs | input | OFF_W (6) | Source offset loaded on start |
| start_dst_offs | input | OFF_W (6) | Destination offset loaded on start |
| start_sub_offs | input | 2 | Sub-element offset loaded on start |
| busy | output | 1 | Loop running |
| issue | output | 1 | Element operation issued this cycle |
| src_reg | output | REG_W (7) | Source register number for this issue |
| dst_reg | output | REG_W (7) | Destination register number for this issue |
| sub_idx | output | 2 | Sub-element index for this issue |
| done | output | 1 | One-cycle completion pulse |
| src_offs | output | OFF_W (6) | Live source offset |
| dst_offs | output | OFF_W (6) | Live destination offset |
| sub_offs | output | 2 | Live sub-element offset |

## Verification
A corrupted offset or sub-element counter shows on `src_reg`, `dst_reg` or `sub_idx` at the very next issue. It also changes how many issues happen before `done`, so each run compares the whole issue sequence and its length with a hand-derived list. A wrong state or a bad finish decision moves the `done` pulse by one or more cycles, or leaves nonzero offsets at the ports. For this reason, the cycle of `done` and the offsets read while it is high are both checked directly.

// File: rtl/eloop_pkg.sv
package eloop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } loop_state_t;

    typedef struct packed {
        logic src_en;
        logic dst_en;
        logic inv;
    } pred_ctl_t;

    // Low bits select which side is masked; top bit inverts the sense.
    // With neither side selected the inversion bit has no effect.
    function automatic pred_ctl_t decode_tpred(input logic [2:0] code);
        pred_ctl_t d;
        d.src_en = code[0];
        d.dst_en = code[1];
        d.inv    = code[2];
        return d;
    endfunction

endpackage

// File: rtl/eloop_pred_pick.sv
module eloop_pred_pick #(
    parameter int MAX_VL = 64,
    parameter int OFF_W  = 6
) (
    input  logic              en,
    input  logic              inv,
    input  logic [MAX_VL-1:0] mask,
    input  logic [OFF_W-1:0]  offs,
    output logic              active
);
    // An unpredicated side is always active.
    always_comb begin
        active = !en || (mask[offs] ^ inv);
    end
endmodule

// File: rtl/eloop_regmap.sv
module eloop_regmap #(
    parameter int REG_W = 7,
    parameter int OFF_W = 6
) (
    input  logic [REG_W-1:0] base,
    input  logic             is_vec,
    input  logic [OFF_W-1:0] offs,
    output logic [REG_W-1:0] reg_num
);
    // Vector operands step with the element offset; scalars stay fixed.
    always_comb begin
        reg_num = is_vec ? (base + REG_W'(offs)) : base;
    end
endmodule

// File: rtl/eloop_seq.sv
module eloop_seq
    import eloop_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    localparam int OFF_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hold,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        svlen,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [2:0]        tpred,
    input  logic [MAX_VL-1:0] mask_a,
    input  logic [MAX_VL-1:0] mask_b,
    input  logic [OFF_W-1:0]  start_src_offs,
    input  logic [OFF_W-1:0]  start_dst_offs,
    input  logic [1:0]        start_sub_offs,
    output logic              busy,
    output logic              issue,
    output logic [REG_W-1:0]  src_reg,
    output logic [REG_W-1:0]  dst_reg,
    output logic [1:0]        sub_idx,
    output logic              done,
    output logic [OFF_W-1:0]  src_offs,
    output logic [OFF_W-1:0]  dst_offs,
    output logic [1:0]        sub_offs
);

    // Operand index 0 is the source, 1 is the destination.
    localparam int NOPS = 2;

    loop_state_t       st_q, st_d;
    logic [VL_W-1:0]   vl_q;
    logic [1:0]        svlen_q;
    logic [NOPS-1:0]   vec_q;
    logic [REG_W-1:0]  base_q [NOPS];
    pred_ctl_t         pred_q;
    logic [OFF_W-1:0]  off_q  [NOPS];
    logic [1:0]        sub_q, sub_d;

    logic [MAX_VL-1:0] msk    [NOPS];
    logic [NOPS-1:0]   pen;
    logic [NOPS-1:0]   act;
    logic [REG_W-1:0]  rnum   [NOPS];
    logic [VL_W-1:0]   nxt_off [NOPS];
    logic              running, fire, last_sub, scal_stop, finish, empty;

    assign msk[0] = mask_a;
    assign msk[1] = mask_b;
    assign pen[0] = pred_q.src_en;
    assign pen[1] = pred_q.dst_en;

    // Per-operand predicate lookup and register numbering.
    for (genvar i = 0; i < NOPS; i++) begin : g_op
        eloop_pred_pick #(.MAX_VL(MAX_VL), .OFF_W(OFF_W)) u_pick (
            .en     (pen[i]),
            .inv    (pred_q.inv),
            .mask   (msk[i]),
            .offs   (off_q[i]),
            .active (act[i])
        );
        eloop_regmap #(.REG_W(REG_W), .OFF_W(OFF_W)) u_map (
            .base    (base_q[i]),
            .is_vec  (vec_q[i]),
            .offs    (off_q[i]),
            .reg_num (rnum[i])
        );
    end

    // Step decision for the current cycle.
    always_comb begin
        running   = (st_q == ST_RUN) && !hold;
        fire      = running && act[0] && act[1];
        last_sub  = (sub_q == svlen_q);
        for (int i = 0; i < NOPS; i++) begin
            nxt_off[i] = VL_W'(off_q[i]);
            if (fire ? last_sub : (running && !act[i])) begin
                nxt_off[i] = VL_W'(off_q[i]) + VL_W'(1);
            end
        end
        scal_stop = fire && last_sub &&
                    ((pen[0] && !vec_q[0]) || (pen[1] && !vec_q[1]));
        finish    = running && (scal_stop || (nxt_off[0] >= vl_q) ||
                                (nxt_off[1] >= vl_q));
        // A skip always lands at the start of a new group.
        sub_d     = (fire && !last_sub) ? (sub_q + 2'd1) : 2'd0;
        empty     = (VL_W'(start_src_offs) >= vl) ||
                    (VL_W'(start_dst_offs) >= vl);
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)  st_d = empty ? ST_DONE : ST_RUN;
            ST_RUN:  if (finish) st_d = ST_DONE;
            ST_DONE:             st_d = ST_IDLE;
            default:             st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Configuration capture and loop counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q      <= '0;
            svlen_q   <= '0;
            vec_q     <= '0;
            pred_q    <= '0;
            sub_q     <= '0;
            for (int i = 0; i < NOPS; i++) begin
                base_q[i] <= '0;
                off_q[i]  <= '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    vl_q      <= vl;
                    svlen_q   <= svlen;
                    vec_q     <= {dst_vec, src_vec};
                    base_q[0] <= src_base;
                    base_q[1] <= dst_base;
                    pred_q    <= decode_tpred(tpred);
                    off_q[0]  <= empty ? '0 : start_src_offs;
                    off_q[1]  <= empty ? '0 : start_dst_offs;
                    sub_q     <= empty ? '0 : start_sub_offs;
                end
                ST_RUN: begin
                    if (finish) begin
                        off_q[0] <= '0;
                        off_q[1] <= '0;
                        sub_q    <= '0;
                    end else if (!hold) begin
                        off_q[0] <= OFF_W'(nxt_off[0]);
                        off_q[1] <= OFF_W'(nxt_off[1]);
                        sub_q    <= sub_d;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy     = (st_q == ST_RUN);
        done     = (st_q == ST_DONE);
        issue    = fire;
        src_reg  = rnum[0];
        dst_reg  = rnum[1];
        sub_idx  = sub_q;
        src_offs = off_q[0];
        dst_offs = off_q[1];
        sub_offs = sub_q;
    end

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !issue);

    p_scalar_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue && $past(issue) && !vec_q[0] |-> $stable(src_reg));

    p_sub_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> sub_idx <= svlen_q);

    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (VL_W'(src_offs) < vl_q) && (VL_W'(dst_offs) < vl_q));

    p_group_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (sub_idx != 2'd0) && $past(busy) |->
            $stable(src_offs) && $stable(dst_offs));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (src_offs == '0) && (dst_offs == '0) && (sub_offs == '0));

    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hold |=> busy && $stable(src_offs) && $stable(dst_offs)
                         && $stable(sub_offs));

endmodule

// File: tb/eloop_seq_test.sv
`timescale 1ns/100ps
module eloop_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, hold = 1'b0;
    logic [6:0]  vl = '0;
    logic [1:0]  svlen = '0;
    logic        src_vec = 1'b0, dst_vec = 1'b0;
    logic [6:0]  src_base = '0, dst_base = '0;
    logic [2:0]  tpred = '0;
    logic [63:0] mask_a = '0, mask_b = '0;
    logic [5:0]  start_src_offs = '0, start_dst_offs = '0;
    logic [1:0]  start_sub_offs = '0;
    logic        busy, issue, done;
    logic [6:0]  src_reg, dst_reg;
    logic [1:0]  sub_idx, sub_offs;
    logic [5:0]  src_offs, dst_offs;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int ngot;
    logic [15:0] got [16];

    always #2.5 clk = ~clk;

    eloop_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold(hold), .vl(vl),
        .svlen(svlen), .src_vec(src_vec), .dst_vec(dst_vec),
        .src_base(src_base), .dst_base(dst_base), .tpred(tpred),
        .mask_a(mask_a), .mask_b(mask_b), .start_src_offs(start_src_offs),
        .start_dst_offs(start_dst_offs), .start_sub_offs(start_sub_offs),
        .busy(busy), .issue(issue), .src_reg(src_reg), .dst_reg(dst_reg),
        .sub_idx(sub_idx), .done(done), .src_offs(src_offs),
        .dst_offs(dst_offs), .sub_offs(sub_offs)
    );

    function automatic logic [15:0] ev(input int s, input int d, input int k);
        return {s[6:0], d[6:0], k[1:0]};
    endfunction

    typedef struct packed {
        logic [6:0]   vl;
        logic [1:0]   sl;
        logic         sv;
        logic         dv;
        logic [6:0]   sb;
        logic [6:0]   db;
        logic [2:0]   tp;
        logic [7:0]   ma;
        logic [7:0]   mb;
        logic [3:0]   cnt;
        logic [127:0] seq;
    } case_t;

    localparam int NCASE = 14;
    // Expected issue lists {src,dst,sub}, first issue in the top 16 bits.
    localparam case_t TBL [NCASE] = '{
        // R2 both vectors step
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd8, 7'd20, 3'b000, 8'h00, 8'h00, 4'd4,
          {ev(8,20,0), ev(9,21,0), ev(10,22,0), ev(11,23,0), 64'd0}},
        // R3 code 01 gives two sub-elements
        '{7'd3, 2'd1, 1'b1, 1'b1, 7'd0, 7'd40, 3'b000, 8'h00, 8'h00, 4'd6,
          {ev(0,40,0), ev(0,40,1), ev(1,41,0), ev(1,41,1), ev(2,42,0), ev(2,42,1), 32'd0}},
        // R2 scalar source fixed
        '{7'd3, 2'd0, 1'b0, 1'b1, 7'd5, 7'd10, 3'b000, 8'h00, 8'h00, 4'd3,
          {ev(5,10,0), ev(5,11,0), ev(5,12,0), 80'd0}},
        // R4 R5 source mask only (compress)
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd0, 7'd32, 3'b001, 8'h0A, 8'h00, 4'd2,
          {ev(1,32,0), ev(3,33,0), 96'd0}},
        // R4 R5 destination mask only (expand)
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd0, 7'd32, 3'b010, 8'h00, 8'h06, 4'd2,
          {ev(0,33,0), ev(1,34,0), 96'd0}},
        // R5 both masks
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd0, 7'd32, 3'b011, 8'h05, 8'h0C, 4'd2,
          {ev(0,34,0), ev(2,35,0), 96'd0}},
        // R4 inverted source mask
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd0, 7'd32, 3'b101, 8'h0A, 8'h00, 4'd2,
          {ev(0,32,0), ev(2,33,0), 96'd0}},
        // R4 code 100 is unpredicated
        '{7'd2, 2'd0, 1'b1, 1'b1, 7'd3, 7'd7, 3'b100, 8'h00, 8'h00, 4'd2,
          {ev(3,7,0), ev(4,8,0), 96'd0}},
        // R7 predicated scalar destination
        '{7'd6, 2'd0, 1'b1, 1'b0, 7'd16, 7'd9, 3'b010, 8'h00, 8'h04, 4'd1,
          {ev(16,9,0), 112'd0}},
        // R7 predicated scalar source
        '{7'd5, 2'd0, 1'b0, 1'b1, 7'd4, 7'd50, 3'b001, 8'h06, 8'h00, 4'd1,
          {ev(4,50,0), 112'd0}},
        // R6 group of four gated by one bit
        '{7'd2, 2'd3, 1'b1, 1'b1, 7'd0, 7'd60, 3'b001, 8'h02, 8'h00, 4'd4,
          {ev(1,60,0), ev(1,60,1), ev(1,60,2), ev(1,60,3), 64'd0}},
        // R3 code 10 gives three sub-elements
        '{7'd1, 2'd2, 1'b0, 1'b0, 7'd2, 7'd3, 3'b000, 8'h00, 8'h00, 4'd3,
          {ev(2,3,0), ev(2,3,1), ev(2,3,2), 80'd0}},
        // R2 register number wraps
        '{7'd3, 2'd0, 1'b1, 1'b1, 7'd126, 7'd0, 3'b000, 8'h00, 8'h00, 4'd3,
          {ev(126,0,0), ev(127,1,0), ev(0,2,0), 80'd0}},
        // R8 mask all inactive: no issue
        '{7'd4, 2'd0, 1'b1, 1'b1, 7'd0, 7'd0, 3'b001, 8'h00, 8'h00, 4'd0,
          {128'd0}}
    };

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse start, then gather issues until done (sampled mid-cycle).
    task automatic run_loop(output int done_at);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ngot = 0;
        done_at = -1;
        n = 0;
        while (n < 200) begin
            #1;
            if (issue && ngot < 16) begin
                got[ngot] = {src_reg, dst_reg, sub_idx};
                ngot++;
            end
            if (done) begin
                done_at = n;
                check(src_offs == 0 && dst_offs == 0 && sub_offs == 0,
                      "R8 offsets zero at done", int'(src_offs), 0);
                break;
            end
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        #1;
        check(!done, "R8 done single cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int dat;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(!busy && !issue && !done, "R1 flags idle",
              int'({busy, issue, done}), 0);
        check(src_offs == 0 && dst_offs == 0 && sub_offs == 0, "R1 offsets",
              int'(src_offs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy && !done, "R1 after release", int'({busy, done}), 0);

        // Table walk
        for (int c = 0; c < NCASE; c++) begin
            vl = TBL[c].vl; svlen = TBL[c].sl;
            src_vec = TBL[c].sv; dst_vec = TBL[c].dv;
            src_base = TBL[c].sb; dst_base = TBL[c].db;
            tpred = TBL[c].tp;
            mask_a = {56'd0, TBL[c].ma}; mask_b = {56'd0, TBL[c].mb};
            start_src_offs = '0; start_dst_offs = '0; start_sub_offs = '0;
            run_loop(dat);
            check(dat >= 0, "R8 done seen", dat, 0);
            check(ngot == int'(TBL[c].cnt), "R5 issue count", ngot,
                  int'(TBL[c].cnt));
            for (int k = 0; k < int'(TBL[c].cnt) && k < ngot; k++) begin
                check(got[k] == TBL[c].seq[127-16*k -: 16],
                      "R2/R3/R6 issue value", int'(got[k]),
                      int'(TBL[c].seq[127-16*k -: 16]));
            end
        end

        // R9 vl zero
        vl = 7'd0; tpred = 3'b000; svlen = 2'd0;
        run_loop(dat);
        check(dat == 0, "R9 done first cycle", dat, 0);
        check(ngot == 0, "R9 no issue", ngot, 0);

        // R9 start offset already at vl
        vl = 7'd2; start_src_offs = 6'd2;
        run_loop(dat);
        check(dat == 0 && ngot == 0, "R9 start offset beyond vl", ngot, 0);

        // R11 resume from offsets
        vl = 7'd5; src_vec = 1'b1; dst_vec = 1'b1;
        src_base = 7'd0; dst_base = 7'd10;
        start_src_offs = 6'd3; start_dst_offs = 6'd3; start_sub_offs = 2'd0;
        run_loop(dat);
        check(ngot == 2, "R11 resume count", ngot, 2);
        check(got[0] == ev(3,13,0), "R11 resume first", int'(got[0]),
              int'(ev(3,13,0)));

        // R11 resume mid-group
        vl = 7'd3; svlen = 2'd1;
        start_src_offs = 6'd2; start_dst_offs = 6'd2; start_sub_offs = 2'd1;
        run_loop(dat);
        check(ngot == 1, "R11 sub resume count", ngot, 1);
        check(got[0] == ev(2,12,1), "R11 sub resume value", int'(got[0]),
              int'(ev(2,12,1)));

        // R10 hold freezes the loop
        vl = 7'd4; svlen = 2'd0;
        start_src_offs = '0; start_dst_offs = '0; start_sub_offs = '0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(issue && src_reg == 7'd0, "R10 first issue", int'(src_reg), 0);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            hold = 1'b1;
            #1;
            check(!issue, "R10 no issue while held", int'(issue), 0);
            check(src_offs == 6'd1 && dst_offs == 6'd1,
                  "R10 offsets frozen", int'(src_offs), 1);
        end
        @(negedge clk);
        hold = 1'b0;
        ngot = 0;
        for (int n = 0; n < 20; n++) begin
            #1;
            if (issue) begin
                got[ngot] = {src_reg, dst_reg, sub_idx};
                ngot++;
            end
            if (done) break;
            @(negedge clk);
        end
        check(ngot == 3, "R10 remaining issues", ngot, 3);
        check(got[2] == ev(3,13,0), "R10 last issue", int'(got[2]),
              int'(ev(3,13,0)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule